// File: doc/BRIEF.md
# Rotate, Shift and Bit-Test Unit

This combinational unit computes the result byte and the new flag byte for the prefixed bit-manipulation group of an 8-bit processor datapath. From a 2-bit group code and a 3-bit select field it performs one of these operations:

- eight rotate and shift variants, including the undocumented shift-left-with-one-fill;
- a single-bit test;
- a single-bit clear;
- a single-bit set.

Operand fetch, memory write-back and opcode decode sit outside the block. The unit only sees the operand, the incoming flags and the decoded fields.

A separate mode input selects the short accumulator-rotate forms. These use a reduced flag update that keeps sign, zero and parity. For the bit test, an indirect-form input chooses where the two undocumented flag copies (X and Y) come from. In register forms they come from the operand. In memory forms they come from an auxiliary byte, the high half of the core's internal address latch.

Top module: `rsb_unit`

## Requirements
- R1: With acc_mode_i=0 and grp_i=0, sel_i selects the operation:
  - 0 rotate left circular; 1 rotate right circular;
  - 2 rotate left through carry; 3 rotate right through carry;
  - 4 shift left with zero fill; 5 shift right keeping bit 7;
  - 6 shift left with bit 0 forced to 1; 7 shift right with bit 7 cleared.
- R2: For every rotate or shift, flag C (bit 0) takes the bit shifted out, and H (bit 4) and N (bit 1) are cleared.
- R3: In the prefixed rotate/shift forms, the flag byte is updated from the result as follows:
  - S (bit 7) is result bit 7;
  - Z (bit 6) is set when the result is zero;
  - P (bit 2) is set for even parity;
  - Y (bit 5) is result bit 5 and X (bit 3) is result bit 3.
- R4: With acc_mode_i=1, sel_i[1:0] selects one of the first four rotates of R1, and grp_i, sel_i[2] and mem_form_i are ignored. C, H, N, X and Y follow R2/R3, while S, Z and P keep their incoming values.
- R5: Bit test (grp_i=1, sel_i = bit index) behaves as follows:
  - result_o equals the operand;
  - H is set, N is cleared and C is kept;
  - Z and P are both set when the tested bit is 0;
  - S is set only when the index is 7 and that bit is 1.
- R6: For the bit test, X and Y come from operand bits 3 and 5 when mem_form_i=0. When mem_form_i=1 they come from latch_hi_i bits 3 and 5.
- R7: grp_i=2 clears bit sel_i and grp_i=3 sets bit sel_i. Both pass flags_i to flags_o unchanged.
- R8: mem_form_i and latch_hi_i have no effect on the outputs for any operation other than the bit test.

Top module ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 8 | Operand byte |
| flags_i | input | 8 | Incoming flag byte |
| grp_i | input | 2 | Operation group: 0 shift, 1 test, 2 clear, 3 set |
| sel_i | input | 3 | Shift variant or bit index |
| mem_form_i | input | 1 | Indirect-memory form of the opcode |
| latch_hi_i | input | 8 | High byte of the internal address latch |
| acc_mode_i | input | 1 | Short accumulator-rotate forms |
| result_o | output | 8 | Result byte |
| flags_o | output | 8 | Outgoing flag byte |

## Verification
The checker evaluates these properties on every input change:
- clear and set leave the flags untouched;
- accumulator mode preserves S, Z and P;
- rotates and shifts clear H and N;
- the bit test passes the operand through, keeps Z equal to P and sets H;
- set and clear force the addressed bit.

The exact shift arithmetic, the carry-in of the through-carry rotates, and parity cannot be seen from those invariants. The same holds for the sign rule of the bit test, the choice of X/Y source, and the insensitivity to mem_form_i outside the bit test. Only the bench sweep shows these, by comparing every operand, select and group against an arithmetic model.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  // flag bit positions, decoded by neighbouring logic
  localparam int unsigned FL_C = 0;
  localparam int unsigned FL_N = 1;
  localparam int unsigned FL_P = 2;
  localparam int unsigned FL_X = 3;
  localparam int unsigned FL_H = 4;
  localparam int unsigned FL_Y = 5;
  localparam int unsigned FL_Z = 6;
  localparam int unsigned FL_S = 7;
  localparam int unsigned FL_W = 8;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'd0,
    GRP_TEST  = 2'd1,
    GRP_CLR   = 2'd2,
    GRP_SET   = 2'd3
  } grp_e;

  typedef enum logic [2:0] {
    SH_ROL   = 3'd0,
    SH_ROR   = 3'd1,
    SH_RLC   = 3'd2,
    SH_RRC   = 3'd3,
    SH_SLZ   = 3'd4,
    SH_SRS   = 3'd5,
    SH_SLO   = 3'd6,
    SH_SRZ   = 3'd7
  } shop_e;
endpackage

// File: rtl/rsb_shifter.sv
module rsb_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [2:0]        op_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o
);
  import rsb_pkg::*;
  localparam int unsigned MSB = DATA_W - 1;

  logic left;
  logic fill;

  always_comb begin
    left = 1'b0;
    fill = 1'b0;
    unique case (shop_e'(op_i))
      SH_ROL: begin left = 1'b1; fill = opnd_i[MSB]; end
      SH_ROR: begin left = 1'b0; fill = opnd_i[0];   end
      SH_RLC: begin left = 1'b1; fill = cin_i;       end
      SH_RRC: begin left = 1'b0; fill = cin_i;       end
      SH_SLZ: begin left = 1'b1; fill = 1'b0;        end
      SH_SRS: begin left = 1'b0; fill = opnd_i[MSB]; end
      SH_SLO: begin left = 1'b1; fill = 1'b1;        end
      SH_SRZ: begin left = 1'b0; fill = 1'b0;        end
      default: ;
    endcase
  end

  assign res_o  = left ? {opnd_i[MSB-1:0], fill} : {fill, opnd_i[MSB:1]};
  assign cout_o = left ? opnd_i[MSB] : opnd_i[0];
endmodule

// File: rtl/rsb_bit_ops.sv
module rsb_bit_ops #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              set_i,
  output logic              tested_o,
  output logic [DATA_W-1:0] modified_o
);
  logic [DATA_W-1:0] mask;

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_mask
      assign mask[b] = (idx_i == IDX_W'(b));
    end
  endgenerate

  assign tested_o   = |(opnd_i & mask);
  assign modified_o = set_i ? (opnd_i | mask) : (opnd_i & ~mask);
endmodule

// File: rtl/rsb_flag_gen.sv
module rsb_flag_gen #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0]       res_i,
  input  logic                    cout_i,
  input  logic                    acc_mode_i,
  input  logic [rsb_pkg::FL_W-1:0] flags_i,
  output logic [rsb_pkg::FL_W-1:0] flags_o
);
  import rsb_pkg::*;

  always_comb begin
    flags_o       = flags_i;
    flags_o[FL_C] = cout_i;
    flags_o[FL_H] = 1'b0;
    flags_o[FL_N] = 1'b0;
    flags_o[FL_X] = res_i[3];
    flags_o[FL_Y] = res_i[5];
    if (!acc_mode_i) begin
      flags_o[FL_S] = res_i[DATA_W-1];
      flags_o[FL_Z] = (res_i == '0);
      flags_o[FL_P] = ~^res_i;
    end
  end
endmodule

// File: rtl/rsb_unit.sv
module rsb_unit #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]        opnd_i,
  input  logic [rsb_pkg::FL_W-1:0] flags_i,
  input  logic [1:0]               grp_i,
  input  logic [IDX_W-1:0]         sel_i,
  input  logic                     mem_form_i,
  input  logic [DATA_W-1:0]        latch_hi_i,
  input  logic                     acc_mode_i,
  output logic [DATA_W-1:0]        result_o,
  output logic [rsb_pkg::FL_W-1:0] flags_o
);
  import rsb_pkg::*;

  logic [2:0]              sh_op;
  logic [DATA_W-1:0]       sh_res;
  logic                    sh_cout;
  logic [FL_W-1:0]         sh_flags;
  logic                    tested;
  logic [DATA_W-1:0]       modified;
  logic [DATA_W-1:0]       xy_src;
  logic [FL_W-1:0]         test_flags;

  // accumulator forms reach only the first four rotates
  assign sh_op = acc_mode_i ? {1'b0, sel_i[1:0]} : 3'(sel_i);

  rsb_shifter #(.DATA_W(DATA_W)) u_shift (
    .opnd_i (opnd_i),
    .op_i   (sh_op),
    .cin_i  (flags_i[FL_C]),
    .res_o  (sh_res),
    .cout_o (sh_cout)
  );

  rsb_flag_gen #(.DATA_W(DATA_W)) u_flags (
    .res_i      (sh_res),
    .cout_i     (sh_cout),
    .acc_mode_i (acc_mode_i),
    .flags_i    (flags_i),
    .flags_o    (sh_flags)
  );

  rsb_bit_ops #(.DATA_W(DATA_W)) u_bits (
    .opnd_i     (opnd_i),
    .idx_i      (sel_i),
    .set_i      (grp_i == GRP_SET),
    .tested_o   (tested),
    .modified_o (modified)
  );

  assign xy_src = mem_form_i ? latch_hi_i : opnd_i;

  always_comb begin
    test_flags       = flags_i;
    test_flags[FL_H] = 1'b1;
    test_flags[FL_N] = 1'b0;
    test_flags[FL_Z] = ~tested;
    test_flags[FL_P] = ~tested;
    test_flags[FL_S] = tested && (sel_i == IDX_W'(DATA_W - 1));
    test_flags[FL_X] = xy_src[3];
    test_flags[FL_Y] = xy_src[5];
  end

  always_comb begin
    result_o = opnd_i;
    flags_o  = flags_i;
    if (acc_mode_i) begin
      result_o = sh_res;
      flags_o  = sh_flags;
    end else begin
      unique case (grp_e'(grp_i))
        GRP_SHIFT: begin result_o = sh_res; flags_o = sh_flags; end
        GRP_TEST:  begin result_o = opnd_i; flags_o = test_flags; end
        GRP_CLR,
        GRP_SET:   begin result_o = modified; flags_o = flags_i; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rsb_unit_chk.sv
module rsb_unit_chk #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input logic [DATA_W-1:0]        opnd_i,
  input logic [rsb_pkg::FL_W-1:0] flags_i,
  input logic [1:0]               grp_i,
  input logic [IDX_W-1:0]         sel_i,
  input logic                     mem_form_i,
  input logic [DATA_W-1:0]        latch_hi_i,
  input logic                     acc_mode_i,
  input logic [DATA_W-1:0]        result_o,
  input logic [rsb_pkg::FL_W-1:0] flags_o
);
  import rsb_pkg::*;

  always_comb begin
    if (!acc_mode_i && grp_i[1])
      p_modify_flags_kept_r7: assert (flags_o == flags_i)
        else $error("flags changed by clear/set");
    if (!acc_mode_i && grp_i == 2'd3)
      p_set_bit_high_r7: assert (result_o[sel_i] == 1'b1)
        else $error("set did not set bit");
    if (!acc_mode_i && grp_i == 2'd2)
      p_clr_bit_low_r7: assert (result_o[sel_i] == 1'b0)
        else $error("clear did not clear bit");
    if (acc_mode_i)
      p_acc_szp_kept_r4: assert (flags_o[FL_S] == flags_i[FL_S] &&
                                 flags_o[FL_Z] == flags_i[FL_Z] &&
                                 flags_o[FL_P] == flags_i[FL_P])
        else $error("accumulator form touched S/Z/P");
    if (acc_mode_i || grp_i == 2'd0)
      p_shift_hn_clear_r2: assert (!flags_o[FL_H] && !flags_o[FL_N])
        else $error("shift left H or N set");
    if (!acc_mode_i && grp_i == 2'd1)
      p_test_flags_r5: assert (result_o == opnd_i && flags_o[FL_Z] == flags_o[FL_P] &&
                               flags_o[FL_H] && flags_o[FL_C] == flags_i[FL_C])
        else $error("bit test flag rule broken");
  end
endmodule

bind rsb_unit rsb_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .opnd_i     (opnd_i),
  .flags_i    (flags_i),
  .grp_i      (grp_i),
  .sel_i      (sel_i),
  .mem_form_i (mem_form_i),
  .latch_hi_i (latch_hi_i),
  .acc_mode_i (acc_mode_i),
  .result_o   (result_o),
  .flags_o    (flags_o)
);

// File: tb/rsb_unit_tb_top.sv
module rsb_unit_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic [7:0] opnd, flg, latch, res, fo;
  logic [1:0] grp;
  logic [2:0] sel;
  logic       mem, acc;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  rsb_unit dut_i (
    .opnd_i     (opnd),
    .flags_i    (flg),
    .grp_i      (grp),
    .sel_i      (sel),
    .mem_form_i (mem),
    .latch_hi_i (latch),
    .acc_mode_i (acc),
    .result_o   (res),
    .flags_o    (fo)
  );

  function automatic int par_even(input int v);
    int cnt = 0;
    for (int i = 0; i < 8; i++) cnt += (v >> i) & 1;
    return (cnt % 2 == 0) ? 1 : 0;
  endfunction

  // arithmetic reference: returns {result, flags}
  function automatic logic [15:0] model(input int o, input int f, input int g,
                                        input int s, input int m, input int l, input int a);
    int r, fl, cin, cout, bt, xs, op;
    r = o; fl = f; cin = f % 2;
    if (a == 1 || g == 0) begin
      op = (a == 1) ? (s % 4) : s;
      case (op)
        0: begin r = (o * 2) % 256 + o / 128; cout = o / 128; end
        1: begin r = o / 2 + (o % 2) * 128;   cout = o % 2;   end
        2: begin r = (o * 2) % 256 + cin;     cout = o / 128; end
        3: begin r = o / 2 + cin * 128;       cout = o % 2;   end
        4: begin r = (o * 2) % 256;           cout = o / 128; end
        5: begin r = o / 2 + (o / 128) * 128; cout = o % 2;   end
        6: begin r = (o * 2) % 256 + 1;       cout = o / 128; end
        default: begin r = o / 2;             cout = o % 2;   end
      endcase
      // keep S,Z,P only in accumulator mode (R4)
      fl = (a == 1) ? (f & 8'hC4) : 0;
      if (a == 0) fl += ((r / 128) * 128) + ((r == 0) ? 64 : 0) + par_even(r) * 4;
      fl += ((r / 32) % 2) * 32 + ((r / 8) % 2) * 8 + cout;
    end else if (g == 1) begin
      bt = (o >> s) % 2;
      xs = (m == 1) ? l : o;
      fl = (f % 2) + 16 + ((bt == 0) ? 68 : 0) + ((s == 7 && bt == 1) ? 128 : 0)
           + ((xs / 32) % 2) * 32 + ((xs / 8) % 2) * 8;
    end else if (g == 2) begin
      r = o - ((o >> s) % 2) * (1 << s);
    end else begin
      r = o + (1 - (o >> s) % 2) * (1 << s);
    end
    return {r[7:0], fl[7:0]};
  endfunction

  function automatic string tag(input int g, input int a, input int m);
    if (a == 1) return "R4";
    case (g)
      0: return (m == 1) ? "R8" : "R1";
      1: return (m == 1) ? "R6" : "R5";
      default: return (m == 1) ? "R8" : "R7";
    endcase
  endfunction

  task automatic apply(input int o, input int f, input int g, input int s,
                       input int m, input int l, input int a);
    logic [15:0] exp;
    string t;
    @(negedge clk_i);
    opnd = 8'(o); flg = 8'(f); grp = 2'(g); sel = 3'(s);
    mem = 1'(m); latch = 8'(l); acc = 1'(a);
    #2;
    exp = model(o, f, g, s, m, l, a);
    t = tag(g, a, m);
    n_chk++;
    if (res !== exp[15:8]) begin
      n_fail++;
      $display("FAIL %s result o=%02h g=%0d s=%0d m=%0d a=%0d got %02h exp %02h",
               t, o, g, s, m, a, res, exp[15:8]);
    end
    n_chk++;
    // flags cover R2 and R3 for shifts
    if (fo !== exp[7:0]) begin
      n_fail++;
      $display("FAIL %s flags o=%02h f=%02h g=%0d s=%0d m=%0d a=%0d got %02h exp %02h",
               t, o, f, g, s, m, a, fo, exp[7:0]);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    opnd = '0; flg = '0; grp = '0; sel = '0; mem = 0; latch = '0; acc = 0;
    repeat (2) @(posedge clk_i);
    rst_ni = 1'b1;
    // idle inputs: rotate of zero gives Z and P set (R3)
    apply(0, 0, 0, 0, 0, 0, 0);
    for (int g = 0; g < 4; g++)
      for (int s = 0; s < 8; s++)
        for (int o = 0; o < 256; o++)
          for (int c = 0; c < 2; c++)
            apply(o, ((o * 37 + s * 11) & 8'hFE) | c, g, s, (o + s + c) % 2,
                  (o ^ 8'h5A) ^ (s * 16), 0);
    // bit test with both X/Y sources on the same operand (R6)
    for (int o = 0; o < 256; o += 3)
      for (int m = 0; m < 2; m++)
        apply(o, 8'h00, 1, o % 8, m, 8'hFF ^ o, 0);
    // accumulator forms with noise on ignored inputs (R4)
    for (int s = 0; s < 8; s++)
      for (int o = 0; o < 256; o++)
        for (int c = 0; c < 2; c++)
          apply(o, ((o * 53) & 8'hFE) | c, (o + s) % 4, s, o % 2, o, 1);
    done = 1'b1;
    summary();
  end

  initial begin
    for (int cyc = 0; cyc < 150000; cyc++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end
endmodule